// File: doc/BRIEF.md
# Channel-Routing SPI Slave Receiver with Host Handshake

This block is the host end of a serial link where a controller is the SPI master and the host is the slave. The host raises a ready line when it can accept traffic. The master then sends frames whenever ready is high. Each frame is delimited by chip select. Its header byte carries a 3-bit channel code in bits [7:5] and, in bits [3:0], the number of payload bytes that follow. Bit 4 is ignored. The receiver buffers a whole frame and checks that its size matches the header. It then replays the frame on one of four output streams: keyboard, mouse, event and command response. Finally it acknowledges the frame by dropping ready low and raising it again, so the master sees a rising edge.

Commands from the host go out in three stages. A local `cmd_start` latches a command byte and raises the command-request line. The master answers with a send-command frame. That frame moves the latched byte into the transmit register and releases command-request. The byte is shifted out on MISO during the next frame, which the master sends on the command-pulled channel. The master's answer arrives later as a command-response frame, which completes the command. A watchdog ends a command that is not answered in time.

The receive sequencer has six states. In SQ_OFF the receiver is disabled and ready is low. SQ_IDLE waits for chip select (IDLE to RECV on frame start). SQ_RECV collects bytes (RECV to CHECK on frame end; RECV to OFF if the enable drops). SQ_CHECK validates and decodes the frame (CHECK to EMIT for a routed frame, CHECK to ACK otherwise). SQ_EMIT streams the buffered bytes (EMIT to ACK after the last byte). SQ_ACK holds ready low (ACK to IDLE, or to OFF when the enable is low).

The command FSM has three states. CM_IDLE goes to CM_REQ on `cmd_start`. CM_REQ goes to CM_LOADED on a send-command frame, or back to IDLE on a response or on timeout. CM_LOADED goes back to IDLE on a response or on timeout.

Top module: `spi_chan_demux`

## Requirements
- R1: A frame is 1 to MAX_BYTES (16) bytes. It is shifted MSB first in SPI mode 0, with MOSI sampled on the rising SCLK edge while `spi_cs_n` is low. The header byte holds the channel in bits [7:5] and the payload length in bits [3:0]. A 16-byte frame is accepted.
- R2: While `rx_en` is low, `host_rdy` is low and frames are ignored: no strobe and no error. Once `rx_en` is high, `host_rdy` is high while the receiver waits for or receives a frame.
- R3: After every frame, good or discarded, `host_rdy` goes low for at least RDY_LOW_CYC (at least 2) cycles and then returns high.
- R4: Frames on channel 0 (keyboard), 1 (mouse) and 2 (event) are replayed whole, header included, one byte per cycle on `out_data`. The strobe is `out_stb` bit 0, 1 or 2 respectively, and `out_last` marks the final byte.
- R5: A channel 3 (send-command) frame, arriving while a request is raised, loads the latched command byte into the transmit register and drops `host_cmd_req`. During the next frame that byte is shifted out MSB first on `spi_miso`, changing on falling SCLK edges. At any other time `spi_miso` sends zeros.
- R6: A channel 4 (command-pulled) frame produces no strobe, no error and no change to the command state.
- R7: `cmd_start` while no command is pending latches `cmd_code`. On the next cycle it raises `host_cmd_req` and `cmd_busy`.
- R8: A channel 5 (command-response) frame is replayed on `out_stb` bit 3. If a command is pending it also pulses `cmd_done` and clears `cmd_busy`.
- R9: If no response arrives within TIMEOUT_CYC cycles of a command start, `host_cmd_req` and `cmd_busy` clear and `cmd_err` pulses.
- R10: `cmd_start` while a command is pending is ignored. The byte latched first is the one later transmitted.
- R11: A frame is discarded with a one-cycle `frame_err` pulse and no strobe when any of these holds: its byte count differs from length+1, it ends on a partial byte, it exceeds MAX_BYTES, or it uses channel 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Chip select from the master, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| host_rdy | output | 1 | Ready line to the master |
| host_cmd_req | output | 1 | Command-request line to the master |
| cmd_start | input | 1 | Local request to send a command |
| cmd_code | input | 8 | Command byte to send |
| cmd_busy | output | 1 | A command is pending |
| cmd_done | output | 1 | One-cycle pulse: the command was answered |
| cmd_err | output | 1 | One-cycle pulse: the command watchdog expired |
| out_data | output | 8 | Byte being replayed on an output stream |
| out_stb | output | 4 | Stream strobes: keyboard, mouse, event, response |
| out_last | output | 1 | Final byte of the replayed frame |
| frame_err | output | 1 | One-cycle pulse: a frame was discarded |

## Verification
The assertions assume that the serial lines are slow against `clk`: each SCLK phase lasts well over the synchroniser depth, and chip select changes only while SCLK is low. They also assume that a send-command frame and a frame start never fall in the same cycle, which holds because frames are separated by a chip-select gap. The bench keeps to this by driving every SCLK phase for six clock cycles. It holds chip select for eight cycles on each side of the bit stream and waits for the ready acknowledgement before starting another frame. It changes inputs one time unit after a clock edge.

// File: rtl/spi_demux_pkg.sv
package spi_demux_pkg;

    localparam int CHAN_MSB    = 7;
    localparam int CHAN_LSB    = 5;
    localparam int LEN_W       = 4;
    localparam int NUM_STREAMS = 4;

    typedef enum logic [2:0] {
        CH_KBD     = 3'd0,
        CH_MOUSE   = 3'd1,
        CH_EVENT   = 3'd2,
        CH_SENDCMD = 3'd3,
        CH_PULLED  = 3'd4,
        CH_RESP    = 3'd5,
        CH_RSV6    = 3'd6,
        CH_RSV7    = 3'd7
    } chan_e;

    typedef enum logic [2:0] {
        SQ_OFF,
        SQ_IDLE,
        SQ_RECV,
        SQ_CHECK,
        SQ_EMIT,
        SQ_ACK
    } seq_state_e;

    typedef enum logic [1:0] {
        CM_IDLE,
        CM_REQ,
        CM_LOADED
    } cmd_state_e;

endpackage

// File: rtl/spi_bit_rx.sv
module spi_bit_rx #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic [7:0] tx_byte,
    input  logic       tx_valid,
    output logic       frm_start,
    output logic       frm_end,
    output logic       frm_partial,
    output logic       byte_vld,
    output logic [7:0] byte_data,
    output logic       miso
);

    localparam int SW = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    logic [SW-1:0] sclk_s, cs_s, mosi_s;
    logic          sclk_d, cs_d;
    logic          sclk_now, cs_now, mosi_now;
    logic          sclk_rise, sclk_fall, cs_fall, cs_rise;
    logic          in_frame_q;
    logic [2:0]    bitc_q;
    logic [6:0]    sh_q;
    logic [7:0]    tx_sh_q;

    assign sclk_now  = sclk_s[SW-1];
    assign cs_now    = cs_s[SW-1];
    assign mosi_now  = mosi_s[SW-1];
    assign sclk_rise = sclk_now & ~sclk_d;
    assign sclk_fall = ~sclk_now & sclk_d;
    assign cs_fall   = ~cs_now & cs_d;
    assign cs_rise   = cs_now & ~cs_d;

    // input synchronisers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_s <= '0;
            cs_s   <= '1;
            mosi_s <= '0;
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_s <= {sclk_s[SW-2:0], sclk};
            cs_s   <= {cs_s[SW-2:0], cs_n};
            mosi_s <= {mosi_s[SW-2:0], mosi};
            sclk_d <= sclk_now;
            cs_d   <= cs_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_frame_q  <= 1'b0;
            bitc_q      <= '0;
            sh_q        <= '0;
            tx_sh_q     <= '0;
            frm_start   <= 1'b0;
            frm_end     <= 1'b0;
            frm_partial <= 1'b0;
            byte_vld    <= 1'b0;
            byte_data   <= '0;
        end else begin
            frm_start <= 1'b0;
            frm_end   <= 1'b0;
            byte_vld  <= 1'b0;
            if (!en) begin
                in_frame_q <= 1'b0;
                bitc_q     <= '0;
            end else if (cs_fall) begin
                in_frame_q <= 1'b1;
                bitc_q     <= '0;
                frm_start  <= 1'b1;
                tx_sh_q    <= tx_valid ? tx_byte : 8'h00;
            end else if (cs_rise && in_frame_q) begin
                in_frame_q  <= 1'b0;
                frm_end     <= 1'b1;
                frm_partial <= (bitc_q != 3'd0);
                bitc_q      <= '0;
            end else if (in_frame_q) begin
                if (sclk_rise) begin
                    sh_q   <= {sh_q[5:0], mosi_now};
                    bitc_q <= bitc_q + 3'd1;
                    if (bitc_q == 3'd7) begin
                        byte_vld  <= 1'b1;
                        byte_data <= {sh_q, mosi_now};
                    end
                end
                if (sclk_fall) begin
                    tx_sh_q <= {tx_sh_q[6:0], 1'b0};
                end
            end
        end
    end

    assign miso = in_frame_q & tx_sh_q[7];

    // a completed byte is only reported inside a frame
    AST_BYTE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(in_frame_q)); // R1

endmodule

// File: rtl/frame_seq.sv
module frame_seq
    import spi_demux_pkg::*;
#(
    parameter int MAX_BYTES   = 16,
    parameter int RDY_LOW_CYC = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic                   frm_start,
    input  logic                   frm_end,
    input  logic                   frm_partial,
    input  logic                   byte_vld,
    input  logic [7:0]             byte_data,
    output logic                   rdy,
    output logic [7:0]             out_data,
    output logic [NUM_STREAMS-1:0] out_stb,
    output logic                   out_last,
    output logic                   frame_err,
    output logic                   ev_sendcmd,
    output logic                   ev_resp
);

    localparam int CNT_W = $clog2(MAX_BYTES + 1);
    localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
    localparam int LOW_N = (RDY_LOW_CYC < 2) ? 2 : RDY_LOW_CYC;
    localparam int ACK_W = $clog2(LOW_N + 1);

    seq_state_e state_q, state_d;

    logic [7:0]       fbuf [MAX_BYTES];
    logic [CNT_W-1:0] cnt_q, idx_q;
    logic [ACK_W-1:0] ack_q;
    logic             ovf_q, part_q;
    logic [1:0]       sel_q;

    logic [7:0]       hdr;
    chan_e            chan;
    logic             size_ok, good, routed, last_byte;
    logic [1:0]       sel_d;

    // header decode and validity
    always_comb begin
        hdr     = fbuf[0];
        chan    = chan_e'(hdr[CHAN_MSB:CHAN_LSB]);
        size_ok = (cnt_q != '0) &&
                  (int'(cnt_q) == int'(hdr[LEN_W-1:0]) + 1);
        good    = size_ok && !ovf_q && !part_q &&
                  (chan != CH_RSV6) && (chan != CH_RSV7);
        routed  = (chan == CH_KBD) || (chan == CH_MOUSE) ||
                  (chan == CH_EVENT) || (chan == CH_RESP);
        unique case (chan)
            CH_KBD:   sel_d = 2'd0;
            CH_MOUSE: sel_d = 2'd1;
            CH_EVENT: sel_d = 2'd2;
            default:  sel_d = 2'd3;
        endcase
        last_byte = (idx_q == cnt_q - CNT_W'(1));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SQ_OFF;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_OFF:   if (en) state_d = SQ_IDLE;
            SQ_IDLE:  if (!en) state_d = SQ_OFF;
                      else if (frm_start) state_d = SQ_RECV;
            SQ_RECV:  if (!en) state_d = SQ_OFF;
                      else if (frm_end) state_d = SQ_CHECK;
            SQ_CHECK: state_d = (good && routed) ? SQ_EMIT : SQ_ACK;
            SQ_EMIT:  if (last_byte) state_d = SQ_ACK;
            SQ_ACK:   if (ack_q == ACK_W'(LOW_N - 1))
                          state_d = en ? SQ_IDLE : SQ_OFF;
            default:  state_d = SQ_OFF;
        endcase
    end

    // outputs
    always_comb begin
        rdy        = 1'b0;
        out_stb    = '0;
        out_data   = 8'h00;
        out_last   = 1'b0;
        frame_err  = 1'b0;
        ev_sendcmd = 1'b0;
        ev_resp    = 1'b0;
        unique case (state_q)
            SQ_IDLE, SQ_RECV: rdy = 1'b1;
            SQ_CHECK: begin
                frame_err  = !good;
                ev_sendcmd = good && (chan == CH_SENDCMD);
                ev_resp    = good && (chan == CH_RESP);
            end
            SQ_EMIT: begin
                out_stb[sel_q] = 1'b1;
                out_data       = fbuf[idx_q[IDX_W-1:0]];
                out_last       = last_byte;
            end
            default: ;
        endcase
    end

    // frame buffer
    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_buf
        always_ff @(posedge clk) begin
            if (state_q == SQ_RECV && byte_vld && int'(cnt_q) == g)
                fbuf[g] <= byte_data;
        end
    end

    // counters and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            idx_q  <= '0;
            ack_q  <= '0;
            ovf_q  <= 1'b0;
            part_q <= 1'b0;
            sel_q  <= '0;
        end else begin
            unique case (state_q)
                SQ_IDLE: if (frm_start) begin
                    cnt_q  <= '0;
                    ovf_q  <= 1'b0;
                    part_q <= 1'b0;
                end
                SQ_RECV: begin
                    if (byte_vld) begin
                        if (int'(cnt_q) == MAX_BYTES) ovf_q <= 1'b1;
                        else                          cnt_q <= cnt_q + CNT_W'(1);
                    end
                    if (frm_end) part_q <= frm_partial;
                end
                SQ_CHECK: begin
                    idx_q <= '0;
                    ack_q <= '0;
                    sel_q <= sel_d;
                end
                SQ_EMIT: idx_q <= idx_q + CNT_W'(1);
                SQ_ACK:  ack_q <= ack_q + ACK_W'(1);
                default: ;
            endcase
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) <= MAX_BYTES); // R1
    AST_RDY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rdy) && en) |=> !rdy); // R3
    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_stb)); // R4
    AST_ERR_NO_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> (out_stb == '0)); // R11

endmodule

// File: rtl/cmd_handshake.sv
module cmd_handshake
    import spi_demux_pkg::*;
#(
    parameter int TIMEOUT_CYC = 40_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_start,
    input  logic [7:0] cmd_code,
    input  logic       ev_sendcmd,
    input  logic       ev_resp,
    input  logic       frm_start,
    output logic       cmd_req,
    output logic       cmd_busy,
    output logic       cmd_done,
    output logic       cmd_err,
    output logic [7:0] tx_byte,
    output logic       tx_valid
);

    localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);

    cmd_state_e state_q, state_d;
    logic [TMR_W-1:0] tmr_q;
    logic [7:0]       code_q;
    logic             expired;

    assign expired = (state_q != CM_IDLE) && (tmr_q == TMR_W'(TIMEOUT_CYC - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CM_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CM_IDLE:   if (cmd_start) state_d = CM_REQ;
            CM_REQ:    if (ev_resp || expired) state_d = CM_IDLE;
                       else if (ev_sendcmd) state_d = CM_LOADED;
            CM_LOADED: if (ev_resp || expired) state_d = CM_IDLE;
            default:   state_d = CM_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_req  = (state_q == CM_REQ);
        cmd_busy = (state_q != CM_IDLE);
        tx_byte  = code_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q    <= '0;
            code_q   <= '0;
            tx_valid <= 1'b0;
            cmd_done <= 1'b0;
            cmd_err  <= 1'b0;
        end else begin
            cmd_done <= (state_q != CM_IDLE) && ev_resp;
            cmd_err  <= expired && !ev_resp;
            if (state_q == CM_IDLE) begin
                tmr_q <= '0;
                if (cmd_start) code_q <= cmd_code;
            end else begin
                tmr_q <= tmr_q + TMR_W'(1);
            end
            if (state_q == CM_REQ && ev_sendcmd && !ev_resp && !expired)
                tx_valid <= 1'b1;
            else if (frm_start || (expired && !ev_resp))
                tx_valid <= 1'b0;
        end
    end

    AST_REQ_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_req) |-> $past(cmd_start)); // R7
    AST_SENDCMD_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_sendcmd && cmd_req) |=> !cmd_req); // R5
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> !cmd_req); // R8
    AST_ERR_REQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> (!cmd_req && !$past(cmd_done))); // R9
    AST_REFUSE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_busy && cmd_start) |=> $stable(code_q)); // R10

endmodule

// File: rtl/spi_chan_demux.sv
module spi_chan_demux
    import spi_demux_pkg::*;
#(
    parameter int MAX_BYTES   = 16,
    parameter int RDY_LOW_CYC = 4,
    parameter int TIMEOUT_CYC = 40_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic       spi_sclk,
    input  logic       spi_cs_n,
    input  logic       spi_mosi,
    output logic       spi_miso,
    output logic       host_rdy,
    output logic       host_cmd_req,
    input  logic       cmd_start,
    input  logic [7:0] cmd_code,
    output logic       cmd_busy,
    output logic       cmd_done,
    output logic       cmd_err,
    output logic [7:0] out_data,
    output logic [3:0] out_stb,
    output logic       out_last,
    output logic       frame_err
);

    logic       frm_start, frm_end, frm_partial, byte_vld;
    logic [7:0] byte_data, tx_byte;
    logic       tx_valid, ev_sendcmd, ev_resp;

    spi_bit_rx #(.SYNC_STAGES(SYNC_STAGES)) u_bit_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (rx_en),
        .sclk       (spi_sclk),
        .cs_n       (spi_cs_n),
        .mosi       (spi_mosi),
        .tx_byte    (tx_byte),
        .tx_valid   (tx_valid),
        .frm_start  (frm_start),
        .frm_end    (frm_end),
        .frm_partial(frm_partial),
        .byte_vld   (byte_vld),
        .byte_data  (byte_data),
        .miso       (spi_miso)
    );

    frame_seq #(.MAX_BYTES(MAX_BYTES), .RDY_LOW_CYC(RDY_LOW_CYC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (rx_en),
        .frm_start  (frm_start),
        .frm_end    (frm_end),
        .frm_partial(frm_partial),
        .byte_vld   (byte_vld),
        .byte_data  (byte_data),
        .rdy        (host_rdy),
        .out_data   (out_data),
        .out_stb    (out_stb),
        .out_last   (out_last),
        .frame_err  (frame_err),
        .ev_sendcmd (ev_sendcmd),
        .ev_resp    (ev_resp)
    );

    cmd_handshake #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_start (cmd_start),
        .cmd_code  (cmd_code),
        .ev_sendcmd(ev_sendcmd),
        .ev_resp   (ev_resp),
        .frm_start (frm_start),
        .cmd_req   (host_cmd_req),
        .cmd_busy  (cmd_busy),
        .cmd_done  (cmd_done),
        .cmd_err   (cmd_err),
        .tx_byte   (tx_byte),
        .tx_valid  (tx_valid)
    );

endmodule

// File: tb/spi_chan_demux_tb.sv
module spi_chan_demux_tb_top;

    localparam int RDY_LOW = 4;
    localparam int TMO     = 4000;
    localparam int HALF    = 6;
    localparam int NVEC    = 10;

    // {nbytes[40:36], b0..b3[35:4], stream[3:1] (4 = none), err[0]}
    localparam logic [40:0] VECS [NVEC] = '{
        {5'd1, 32'h00000000, 3'd0, 1'b0},
        {5'd3, 32'h22A55A00, 3'd1, 1'b0},
        {5'd2, 32'h413C0000, 3'd2, 1'b0},
        {5'd2, 32'hA1770000, 3'd3, 1'b0},
        {5'd1, 32'h80000000, 3'd4, 1'b0},
        {5'd2, 32'h02110000, 3'd4, 1'b1},
        {5'd1, 32'hC0000000, 3'd4, 1'b1},
        {5'd1, 32'hE0000000, 3'd4, 1'b1},
        {5'd4, 32'h03010203, 3'd0, 1'b0},
        {5'd3, 32'h41AABB00, 3'd4, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0, rx_en = 1'b0;
    logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic cmd_start = 1'b0;
    logic [7:0] cmd_code = 8'h00;
    logic spi_miso, host_rdy, host_cmd_req, cmd_busy, cmd_done, cmd_err;
    logic [7:0] out_data;
    logic [3:0] out_stb;
    logic out_last, frame_err;

    always #5 clk = ~clk;

    spi_chan_demux #(.MAX_BYTES(16), .RDY_LOW_CYC(RDY_LOW), .TIMEOUT_CYC(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .host_rdy(host_rdy), .host_cmd_req(host_cmd_req),
        .cmd_start(cmd_start), .cmd_code(cmd_code),
        .cmd_busy(cmd_busy), .cmd_done(cmd_done), .cmd_err(cmd_err),
        .out_data(out_data), .out_stb(out_stb), .out_last(out_last), .frame_err(frame_err)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    logic [7:0] tx_buf [17];
    logic [7:0] rx_buf [17];
    int   log_n = 0;
    int   log_ch [32];
    logic [7:0] log_d [32];
    logic log_last [32];
    bit   err_seen = 0, done_seen = 0, cerr_seen = 0, bad_stb = 0;
    int   low_run = 0, last_low = 0;

    // output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (out_stb != 4'b0) begin
            if (log_n < 32) begin
                log_ch[log_n]   = (out_stb == 4'b0001) ? 0 : (out_stb == 4'b0010) ? 1 :
                                  (out_stb == 4'b0100) ? 2 : (out_stb == 4'b1000) ? 3 : 9;
                log_d[log_n]    = out_data;
                log_last[log_n] = out_last;
            end
            log_n++;
        end
        if (frame_err) err_seen = 1;
        if (cmd_done)  done_seen = 1;
        if (cmd_err)   cerr_seen = 1;
        if (rx_en && !host_rdy) low_run++;
        else if (low_run != 0) begin last_low = low_run; low_run = 0; end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clear_log();
        log_n = 0; err_seen = 0; done_seen = 0; cerr_seen = 0;
    endtask

    task automatic spi_xfer(input int nbits);
        spi_cs_n = 1'b0;
        tick(8);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = tx_buf[i / 8][7 - (i % 8)];
            tick(HALF);
            rx_buf[i / 8][7 - (i % 8)] = spi_miso;
            spi_sclk = 1'b1;
            tick(HALF);
            spi_sclk = 1'b0;
        end
        tick(8);
        spi_cs_n = 1'b1;
        tick(80);
    endtask

    task automatic one_byte(input logic [7:0] b);
        tx_buf[0] = b;
        rx_buf[0] = 8'hFF;
        spi_xfer(8);
    endtask

    initial begin
        tick(1000_00 * 2);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(5);
        // reset state, receiver disabled
        chk("R2 rdy low while disabled", host_rdy, 0);
        chk("R7 cmd_req idle", host_cmd_req, 0);
        chk("R5 miso idle", spi_miso, 0);
        chk("R4 no strobe at reset", out_stb, 0);
        rst_n = 1'b1;
        tick(3);
        clear_log();
        one_byte(8'h00);
        chk("R2 frame ignored while disabled", log_n, 0);
        chk("R2 no error while disabled", err_seen, 0);
        rx_en = 1'b1;
        tick(3);
        chk("R2 rdy high when enabled", host_rdy, 1);

        // table of vectors
        for (int v = 0; v < NVEC; v++) begin
            int nb;
            int st;
            string tag;
            bit ok;
            nb = int'(VECS[v][40:36]);
            st = int'(VECS[v][3:1]);
            for (int b = 0; b < 4; b++) tx_buf[b] = VECS[v][35 - 8*b -: 8];
            tag = VECS[v][0] ? "R11" : (st == 3) ? "R8" : (st == 4) ? "R6" : "R4";
            clear_log();
            spi_xfer(nb * 8);
            chk(tag, err_seen, VECS[v][0]);
            if (st == 4) chk(tag, log_n, 0);
            else begin
                chk(tag, log_n, nb);
                ok = 1;
                for (int b = 0; b < nb; b++)
                    if (log_ch[b] != st || log_d[b] != tx_buf[b] || log_last[b] != (b == nb - 1)) ok = 0;
                chk({tag, " stream content"}, ok, 1);
            end
            chk("R3 rdy back high", host_rdy, 1);
            chk("R3 rdy low width", last_low >= RDY_LOW, 1);
        end

        // R1: maximum frame, 16 bytes on the event channel
        begin
            bit ok;
            tx_buf[0] = 8'h4F;
            for (int b = 1; b < 16; b++) tx_buf[b] = 8'(b * 17);
            clear_log();
            spi_xfer(16 * 8);
            chk("R1 16-byte frame count", log_n, 16);
            ok = 1;
            for (int b = 0; b < 16; b++) if (log_d[b] != tx_buf[b] || log_ch[b] != 2) ok = 0;
            chk("R1 16-byte frame content", ok, 1);
            chk("R1 16-byte frame no error", err_seen, 0);
        end

        // R11: 17 bytes, and a partial byte
        tx_buf[0] = 8'h0F; tx_buf[16] = 8'h00;
        clear_log();
        spi_xfer(17 * 8);
        chk("R11 oversize error", err_seen, 1);
        chk("R11 oversize no strobe", log_n, 0);
        tx_buf[0] = 8'h00; tx_buf[1] = 8'hFF;
        clear_log();
        spi_xfer(11);
        chk("R11 partial error", err_seen, 1);
        chk("R11 partial no strobe", log_n, 0);
        chk("R3 rdy after discard", host_rdy, 1);

        // R5: send-command frame with no request pending has no effect
        clear_log();
        one_byte(8'h60);
        one_byte(8'h80);
        chk("R5 miso zero without load", rx_buf[0], 8'h00);

        // R7, R10, R5, R6, R8: full command exchange
        cmd_code = 8'h5A; cmd_start = 1'b1;
        tick(1);
        cmd_start = 1'b0;
        chk("R7 cmd_req raised", host_cmd_req, 1);
        chk("R7 busy raised", cmd_busy, 1);
        cmd_code = 8'hC3; cmd_start = 1'b1;
        tick(1);
        cmd_start = 1'b0;
        clear_log();
        one_byte(8'h60);
        chk("R5 miso zero during send-command frame", rx_buf[0], 8'h00);
        chk("R5 cmd_req dropped", host_cmd_req, 0);
        chk("R5 still busy", cmd_busy, 1);
        clear_log();
        one_byte(8'h80);
        chk("R10 first code transmitted", rx_buf[0], 8'h5A);
        chk("R6 pulled frame no strobe", log_n, 0);
        chk("R6 pulled frame no error", err_seen, 0);
        chk("R6 pulled frame keeps busy", cmd_busy, 1);
        one_byte(8'h80);
        chk("R5 miso zero after pull", rx_buf[0], 8'h00);
        clear_log();
        tx_buf[0] = 8'hA1; tx_buf[1] = 8'h42;
        spi_xfer(16);
        chk("R8 response on stream 3", (log_n == 2 && log_ch[0] == 3 && log_d[1] == 8'h42), 1);
        chk("R8 done pulse", done_seen, 1);
        chk("R8 busy cleared", cmd_busy, 0);
        chk("R8 no timeout", cerr_seen, 0);

        // R9: watchdog expiry
        clear_log();
        cmd_code = 8'h11; cmd_start = 1'b1;
        tick(1);
        cmd_start = 1'b0;
        tick(TMO - 20);
        chk("R9 request held before expiry", host_cmd_req, 1);
        tick(40);
        chk("R9 error pulse", cerr_seen, 1);
        chk("R9 cmd_req cleared", host_cmd_req, 0);
        chk("R9 busy cleared", cmd_busy, 0);
        chk("R9 no done", done_seen, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule